// File: doc/BRIEF.md
# Supervised Timebase Source Selector

This block advances a free-running counter from one of two sources. In the internal mode, a prescaler up-counter runs from zero to a programmable compare value. It then wraps and gives one count to the main counter. In the external mode, each rising edge of an asynchronous timebase input advances the counter instead. The external input passes through a two-flop synchronizer and an edge detector before it is used.

A supervisor keeps watch while the external source is selected. It counts system clock cycles since the last external edge, or since external mode was entered. When that count reaches a programmable timeout with no edge, the supervisor raises a one-cycle failure flag and clears the source-select bit. The internal prescaler then takes over. If the compensation bit is set, the counter gets one extra count in the failure cycle, so the timebase does not lose a tick.

Software reaches the block through a small register bus. Reads work in any mode, but writes only take effect when the privilege flag is set. Only software can select the external source. Hardware can only take the selection away.

Top module: `tbase_sel`

## Requirements
- R1: After reset, the control register reads 0, the prescaler compare reads 3, the timeout reads 255, the counter output is 0 and the failure flag is low.
- R2: In internal mode with compare value C, the prescaler counts 0..C. The counter advances once every C+1 cycles, so over N cycles from a cleared prescaler it gains floor(N/(C+1)).
- R3: Any privileged write of 1 to the select bit clears the prescaler. While the select bit is 1, the prescaler stays frozen at zero and cannot advance the counter.
- R4: In external mode, a rising edge of `ext_tb` that is set up before clock edge A advances the counter at clock edge A+2 and not before. Each rising edge gives exactly one count.
- R5: With timeout T, if the select bit was written to 1 at clock edge W and no external edge arrives, `clk_fail_o` is high only between edges W+T and W+T+1. The select bit reads 0 after edge W+T+1. An external edge restarts the timeout count.
- R6: Control bit 1 (the compensation bit) set to 1 gives exactly one extra count at the edge that ends the failure cycle. With the bit at 0, no count is added.
- R7: If a privileged control write lands at the same edge as a hardware clear, the select bit ends up 0. The compensation bit still takes the written value.
- R8: Writes with `reg_priv` low change no register. Reads return the same data whatever the privilege flag is.
- R9: The register map is as follows. Address 0 is control: bit 0 is select (1 = external) and bit 1 is compensation; bits 31:2 read 0 and ignore writes. Address 1 is the prescaler compare value. Address 2 is the timeout. Address 3 reads the counter and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_priv | input | 1 | Privileged access flag |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ext_tb | input | 1 | Asynchronous external timebase input |
| count_o | output | 32 | Free-running counter value |
| clk_fail_o | output | 1 | One-cycle missing-edge indication |

## Verification
The hardest state to reach is a control write that lands at exactly the edge where the supervisor clears the select bit. The bench gets there by counting edges from the write that entered external mode, with no external pulses. It puts a second write on the bus in the cycle the failure flag is seen high, so that it commits at the clearing edge. The failure timing is swept over several timeouts, with compensation both on and off. This shows the flag window, the extra count and the clear to the cycle.

// File: rtl/tbase_sel.sv
module tbase_sel #(
  parameter int          CNT_W    = 32,
  parameter int          PRE_W    = 16,
  parameter int          TMO_W    = 16,
  parameter int unsigned PRE_INIT = 3,
  parameter int unsigned TMO_INIT = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  input  logic        reg_priv,
  output logic [31:0] reg_rdata,
  input  logic        ext_tb,
  output logic [31:0] count_o,
  output logic        clk_fail_o
);
  localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(PRE_INIT);
  localparam logic [TMO_W-1:0] TMO_RST = TMO_W'(TMO_INIT);

  logic [2:0]       ext_q;
  logic             sel, comp;
  logic [PRE_W-1:0] pre_cnt, pre_cmp;
  logic [TMO_W-1:0] wd_cnt, tmo;
  logic [CNT_W-1:0] count;

  wire wr_ok    = reg_we & reg_priv;
  wire wr_ctrl  = wr_ok & (reg_addr == 2'd0);
  wire wr_pre   = wr_ok & (reg_addr == 2'd1);
  wire wr_tmo   = wr_ok & (reg_addr == 2'd2);
  wire ext_rise = ext_q[1] & ~ext_q[2];
  wire tc       = ~sel & (pre_cnt >= pre_cmp);
  wire fail     = sel & ~ext_rise & (wd_cnt == tmo);
  wire step     = sel ? (ext_rise | (fail & comp)) : tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= '0;
      sel     <= 1'b0;
      comp    <= 1'b0;
      pre_cmp <= PRE_RST;
      tmo     <= TMO_RST;
      pre_cnt <= '0;
      wd_cnt  <= '0;
      count   <= '0;
    end else begin
      ext_q <= {ext_q[1:0], ext_tb};
      if (fail)         sel <= 1'b0;
      else if (wr_ctrl) sel <= reg_wdata[0];
      if (wr_ctrl) comp    <= reg_wdata[1];
      if (wr_pre)  pre_cmp <= reg_wdata[PRE_W-1:0];
      if (wr_tmo)  tmo     <= reg_wdata[TMO_W-1:0];
      if ((wr_ctrl & reg_wdata[0]) | sel | tc) pre_cnt <= '0;
      else                                     pre_cnt <= pre_cnt + 1'b1;
      if (!sel || ext_rise) wd_cnt <= '0;
      else                  wd_cnt <= wd_cnt + 1'b1;
      if (step) count <= count + 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {30'd0, comp, sel};
      2'd1:    reg_rdata = 32'(pre_cmp);
      2'd2:    reg_rdata = 32'(tmo);
      default: reg_rdata = 32'(count);
    endcase
  end

  assign count_o    = 32'(count);
  assign clk_fail_o = fail;
endmodule

module tbase_sel_chk #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             comp,
  input logic             fail,
  input logic             ext_rise,
  input logic [CNT_W-1:0] count,
  input logic [PRE_W-1:0] pre_cmp,
  input logic [1:0]       reg_addr,
  input logic             reg_we,
  input logic             reg_priv
);
  p_fail_clears_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !sel);
  p_fail_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
  p_comp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && comp) |=> count == $past(count) + 1'b1);
  p_ext_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !ext_rise && !fail) |=> $stable(count));
  p_sel_by_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel) |-> $past(reg_we && reg_priv && reg_addr == 2'd0));
  p_user_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_priv && reg_addr == 2'd1) |=> $stable(pre_cmp));
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

bind tbase_sel tbase_sel_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .comp(comp), .fail(fail),
  .ext_rise(ext_rise), .count(count), .pre_cmp(pre_cmp),
  .reg_addr(reg_addr), .reg_we(reg_we), .reg_priv(reg_priv)
);

// File: tb/test_tbase_sel.sv
`timescale 1ns/1ps
module test_tbase_sel;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0, reg_priv = 1'b0, ext_tb = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata, count_o;
  logic        clk_fail_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  tbase_sel i_tbase_sel (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_priv = p; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_priv = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); ext_tb = 1'b1;
    repeat (hi) @(negedge clk);
    ext_tb = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state (one edge elapsed, prescaler not yet at terminal count)
    rd(2'd0, v); chk("R1 ctrl", v, 32'd0);
    rd(2'd1, v); chk("R1 compare", v, 32'd3);
    rd(2'd2, v); chk("R1 timeout", v, 32'd255);
    chk("R1 count", count_o, 32'd0);
    chk("R1 fail flag", {31'd0, clk_fail_o}, 32'd0);

    // R8 user-mode writes ignored, reads unaffected by privilege
    wr(2'd0, 32'd3, 1'b0); rd(2'd0, v); chk("R8 ctrl user write", v, 32'd0);
    wr(2'd1, 32'd9, 1'b0); rd(2'd1, v); chk("R8 compare user write", v, 32'd3);
    wr(2'd2, 32'd9, 1'b0); rd(2'd2, v); chk("R8 timeout user write", v, 32'd255);
    reg_priv = 1'b1; rd(2'd1, v); reg_priv = 1'b0; chk("R8 priv read", v, 32'd3);

    // R9 reserved bits and map
    wr(2'd0, 32'hFFFF_FFFC, 1'b1); rd(2'd0, v); chk("R9 reserved bits", v, 32'd0);
    wr(2'd0, 32'hFFFF_FFFE, 1'b1); rd(2'd0, v); chk("R9 comp bit", v, 32'd2);
    wr(2'd0, 32'd0, 1'b1);
    wr(2'd3, 32'd77, 1'b1); rd(2'd3, v); chk("R9 counter readback", v, count_o);
    wr(2'd2, 32'd1000, 1'b1); rd(2'd2, v); chk("R9 timeout rw", v, 32'd1000);

    // R2/R3 prescaler sweep, cleared by entering external mode
    for (int c = 0; c < 8; c++) begin
      wr(2'd1, 32'(c), 1'b1);
      wr(2'd0, 32'd1, 1'b1);
      wr(2'd0, 32'd0, 1'b1);
      c0 = count_o;
      repeat (24) @(negedge clk);
      chk("R2 R3 prescaled rate", count_o - c0, 32'(24 / (c + 1)));
    end

    // R3 external mode ignores prescaler
    wr(2'd1, 32'd0, 1'b1);
    wr(2'd0, 32'd1, 1'b1);
    c0 = count_o;
    repeat (20) @(negedge clk);
    chk("R3 frozen in external mode", count_o - c0, 32'd0);

    // R4 edge latency
    c0 = count_o;
    ext_tb = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 no early count", count_o - c0, 32'd0);
    @(negedge clk);
    chk("R4 count at A+2", count_o - c0, 32'd1);
    ext_tb = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 single count per edge", count_o - c0, 32'd1);

    // R4/R5 pulse trains shorter than timeout keep external mode
    wr(2'd2, 32'd20, 1'b1);
    for (int g = 2; g < 7; g++) begin
      c0 = count_o;
      repeat (5) pulse(2, g);
      repeat (3) @(negedge clk);
      chk("R4 pulse train count", count_o - c0, 32'd5);
      rd(2'd0, v); chk("R5 edges keep select", v[0], 1'b1);
    end
    wr(2'd0, 32'd0, 1'b1);
    wr(2'd1, 32'd50, 1'b1);

    // R5/R6 failure timing sweep
    for (int t = 0; t < 6; t++) begin
      for (int ci = 0; ci < 2; ci++) begin
        wr(2'd2, 32'(t), 1'b1);
        wr(2'd0, {30'd0, ci[0], 1'b1}, 1'b1);
        c0 = count_o;
        for (int k = 0; k < t; k++) begin
          chk("R5 flag early", {31'd0, clk_fail_o}, 32'd0);
          @(negedge clk);
        end
        chk("R5 flag at timeout", {31'd0, clk_fail_o}, 32'd1);
        chk("R6 no count before fail edge", count_o - c0, 32'd0);
        @(negedge clk);
        chk("R5 flag one cycle", {31'd0, clk_fail_o}, 32'd0);
        chk("R6 compensation count", count_o - c0, 32'(ci));
        rd(2'd0, v); chk("R5 select cleared", v, {30'd0, ci[0], 1'b0});
      end
    end

    // R7 collision: write lands at the clearing edge
    wr(2'd2, 32'd3, 1'b1);
    wr(2'd0, 32'd1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 flag before collision", {31'd0, clk_fail_o}, 32'd1);
    reg_addr = 2'd0; reg_wdata = 32'd3; reg_priv = 1'b1; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_priv = 1'b0;
    rd(2'd0, v); chk("R7 hardware clear wins", v, 32'd2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule